// File: doc/BRIEF.md
# Run-Time Reconfigurable Complex / Fixed-Point Multiply-Accumulate Element

This block is a coarse-grained arithmetic element for an array of processing tiles. One datapath serves two number formats, chosen while running by a small mode register. In complex mode each 16-bit operand carries a two's complement real part in its upper byte and an imaginary part in its lower byte. The element forms the full complex product and accumulates the real and imaginary results in two separate signed lanes. In fixed mode the operands are 16-bit integers, read as unsigned or as two's complement according to a mode bit, and the product is accumulated in one wide register.

A new operand pair is accepted every cycle, and each result appears one registered cycle later. Besides accumulation, the mode register can select a third-operand form, in which the result is the third operand plus the product or the third operand minus the product. Two such elements side by side then produce both outputs of a radix-2 butterfly in one cycle. Overflow in accumulation wraps and sets a sticky flag.

Top module: `rmac_unit`

## Requirements
- R1: After synchronous reset the accumulator output is 0, the overflow flag is 0, out_valid is 0, and the mode is fixed unsigned accumulate (mode word 4'b0000).
- R2: The mode word is cfg_data[0]=complex select, cfg_data[1]=signed fixed select, cfg_data[3:2]=operation (00 and 11 accumulate, 01 third plus product, 10 third minus product). A write with cfg_we takes effect on the following cycle. It zeroes the accumulator and the overflow flag, and an in_valid in the same cycle is dropped, so out_valid is 0 on the next cycle.
- R3: In complex mode the operand bits [15:8] hold the real part and bits [7:0] hold the imaginary part, both two's complement. The product (ar·br − ai·bi) + j(ar·bi + ai·br) is accumulated per lane. acc_out carries the real lane in its upper half and the imaginary lane in its lower half.
- R4: In fixed unsigned mode the 32-bit product of the operands is zero-extended and added to the accumulator.
- R5: In fixed signed mode the product of the operands is taken as two's complement and sign-extended before it is added.
- R6: out_valid is asserted exactly one cycle after an accepted in_valid, and acc_out shows that operation's result in the same cycle. Back-to-back pairs are accepted in every cycle.
- R7: acc_clr together with in_valid loads the current product in place of the sum. acc_clr without in_valid zeroes the accumulator. Both forms clear the overflow flag.
- R8: In the third-operand operations the result, not accumulated, is op_c plus or minus the product. op_c is packed and extended like the other operands in the current mode.
- R9: Accumulation wraps modulo the accumulator width. Overflow (signed overflow of either complex lane or of the signed fixed sum, or a carry out in fixed unsigned) sets a flag that stays set until a clear or a mode write.
- R10: A cycle without in_valid, acc_clr or cfg_we leaves acc_out and the overflow flag unchanged and drives out_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_data | input | 4 | Mode word (see R2) |
| in_valid | input | 1 | Operand pair valid |
| acc_clr | input | 1 | Accumulator clear |
| op_a | input | 2*PART_W | First operand |
| op_b | input | 2*PART_W | Second operand |
| op_c | input | 2*PART_W | Third operand for add/subtract forms |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| acc_out | output | 2*CACC_W | Accumulator (complex: real lane high, imaginary lane low) |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench builds the element with PART_W=8 and CACC_W=18, which gives a 36-bit fixed accumulator. At this narrower width the signed complex lane wraps after four extreme products. The unsigned fixed accumulator carries out on the seventeenth full-scale square, and the signed one overflows on the thirty-second product of the most negative value. This makes every wrap and sticky-flag case reachable in a few dozen cycles, while the packing and sign handling stay the same as at the default widths.

// File: rtl/rmac_pkg.sv
package rmac_pkg;

    localparam int CFG_W = 4;

    typedef enum logic [1:0] {
        OP_ACC     = 2'b00,
        OP_ADD_C   = 2'b01,
        OP_SUB_C   = 2'b10,
        OP_ACC_ALT = 2'b11
    } op_e;

    // Mode word: [3:2] operation, [1] signed fixed, [0] complex
    typedef struct packed {
        op_e  op;
        logic is_signed;
        logic cplx;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{op: OP_ACC, is_signed: 1'b0, cplx: 1'b0};

    function automatic logic op_accumulates(input op_e op);
        return (op == OP_ACC) || (op == OP_ACC_ALT);
    endfunction

endpackage

// File: rtl/rmac_cfg_reg.sv
module rmac_cfg_reg
    import rmac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (we) begin
            cfg <= cfg_t'(wdata);
        end
    end

endmodule

// File: rtl/rmac_mult.sv
module rmac_mult
    import rmac_pkg::*;
#(
    parameter int PART_W = 8,
    parameter int CACC_W = 20
) (
    input  cfg_t                    cfg,
    input  logic [2*PART_W-1:0]     a,
    input  logic [2*PART_W-1:0]     b,
    input  logic [2*PART_W-1:0]     c,
    output logic [1:0][CACC_W-1:0]  cprod,
    output logic [1:0][CACC_W-1:0]  cthird,
    output logic [2*CACC_W-1:0]     fprod,
    output logic [2*CACC_W-1:0]     fthird
);

    localparam int OPW    = 2 * PART_W;
    localparam int PP_W   = 2 * PART_W;
    localparam int FP_W   = 2 * OPW;
    localparam int FACC_W = 2 * CACC_W;

    function automatic logic [PP_W-1:0] sx_part(input logic [PART_W-1:0] v);
        return {{PART_W{v[PART_W-1]}}, v};
    endfunction

    function automatic logic [CACC_W-1:0] sx_lane(input logic [PP_W-1:0] v);
        return {{(CACC_W-PP_W){v[PP_W-1]}}, v};
    endfunction

    function automatic logic [CACC_W-1:0] sx_small(input logic [PART_W-1:0] v);
        return {{(CACC_W-PART_W){v[PART_W-1]}}, v};
    endfunction

    // Lane 1 is the real part (upper byte), lane 0 the imaginary part.
    logic [PART_W-1:0] ar, ai, br, bi;
    assign ar = a[OPW-1:PART_W];
    assign ai = a[PART_W-1:0];
    assign br = b[OPW-1:PART_W];
    assign bi = b[PART_W-1:0];

    logic [PP_W-1:0] p_rr, p_ii, p_ri, p_ir;
    assign p_rr = sx_part(ar) * sx_part(br);
    assign p_ii = sx_part(ai) * sx_part(bi);
    assign p_ri = sx_part(ar) * sx_part(bi);
    assign p_ir = sx_part(ai) * sx_part(br);

    assign cprod[1]  = sx_lane(p_rr) - sx_lane(p_ii);
    assign cprod[0]  = sx_lane(p_ri) + sx_lane(p_ir);
    assign cthird[1] = sx_small(c[OPW-1:PART_W]);
    assign cthird[0] = sx_small(c[PART_W-1:0]);

    // Fixed-point product, both interpretations, low FP_W bits are exact.
    logic [FP_W-1:0] fp_u, fp_s;
    assign fp_u = {{OPW{1'b0}}, a} * {{OPW{1'b0}}, b};
    assign fp_s = {{OPW{a[OPW-1]}}, a} * {{OPW{b[OPW-1]}}, b};

    always_comb begin
        if (cfg.is_signed) begin
            fprod  = {{(FACC_W-FP_W){fp_s[FP_W-1]}}, fp_s};
            fthird = {{(FACC_W-OPW){c[OPW-1]}}, c};
        end else begin
            fprod  = {{(FACC_W-FP_W){1'b0}}, fp_u};
            fthird = {{(FACC_W-OPW){1'b0}}, c};
        end
    end

endmodule

// File: rtl/rmac_acc.sv
module rmac_acc
    import rmac_pkg::*;
#(
    parameter int CACC_W = 20
) (
    input  logic                    clk,
    input  logic                    rst,
    input  cfg_t                    cfg,
    input  logic                    cfg_we,
    input  logic                    in_valid,
    input  logic                    acc_clr,
    input  logic [1:0][CACC_W-1:0]  cprod,
    input  logic [1:0][CACC_W-1:0]  cthird,
    input  logic [2*CACC_W-1:0]     fprod,
    input  logic [2*CACC_W-1:0]     fthird,
    output logic [2*CACC_W-1:0]     acc,
    output logic                    ovf,
    output logic                    out_valid
);

    localparam int FACC_W = 2 * CACC_W;
    localparam int LMSB   = CACC_W - 1;
    localparam int FMSB   = FACC_W - 1;

    logic [FACC_W-1:0] acc_q, acc_d;
    logic              ovf_q, ovf_d;
    logic              vld_q;

    // Complex lanes: same structure twice.
    logic [FACC_W-1:0] lane_sum_v, lane_alt_v;
    logic [1:0]        lane_ovf;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [CACC_W-1:0] base, sum, alt;
        assign base = acc_clr ? '0 : acc_q[g*CACC_W +: CACC_W];
        assign sum  = base + cprod[g];
        assign alt  = (cfg.op == OP_SUB_C) ? (cthird[g] - cprod[g])
                                           : (cthird[g] + cprod[g]);
        assign lane_ovf[g] = (base[LMSB] == cprod[g][LMSB]) && (sum[LMSB] != base[LMSB]);
        assign lane_sum_v[g*CACC_W +: CACC_W] = sum;
        assign lane_alt_v[g*CACC_W +: CACC_W] = alt;
    end

    // Fixed-point lane.
    logic [FACC_W-1:0] f_base, f_alt;
    logic [FACC_W:0]   f_sum;
    logic              f_ovf;

    always_comb begin
        f_base = acc_clr ? '0 : acc_q;
        f_sum  = {1'b0, f_base} + {1'b0, fprod};
        if (cfg.is_signed) begin
            f_ovf = (f_base[FMSB] == fprod[FMSB]) && (f_sum[FMSB] != f_base[FMSB]);
        end else begin
            f_ovf = f_sum[FACC_W];
        end
        f_alt = (cfg.op == OP_SUB_C) ? (fthird - fprod) : (fthird + fprod);
    end

    always_comb begin
        acc_d = acc_q;
        ovf_d = ovf_q;
        if (cfg_we) begin
            acc_d = '0;
            ovf_d = 1'b0;
        end else if (in_valid) begin
            if (acc_clr) begin
                ovf_d = 1'b0;
            end
            if (op_accumulates(cfg.op)) begin
                if (cfg.cplx) begin
                    acc_d = lane_sum_v;
                    ovf_d = ovf_d | (|lane_ovf);
                end else begin
                    acc_d = f_sum[FACC_W-1:0];
                    ovf_d = ovf_d | f_ovf;
                end
            end else begin
                acc_d = cfg.cplx ? lane_alt_v : f_alt;
            end
        end else if (acc_clr) begin
            acc_d = '0;
            ovf_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            ovf_q <= 1'b0;
            vld_q <= 1'b0;
        end else begin
            acc_q <= acc_d;
            ovf_q <= ovf_d;
            vld_q <= in_valid && !cfg_we;
        end
    end

    assign acc       = acc_q;
    assign ovf       = ovf_q;
    assign out_valid = vld_q;

endmodule

// File: rtl/rmac_unit.sv
module rmac_unit
    import rmac_pkg::*;
#(
    parameter int PART_W = 8,
    parameter int CACC_W = 20
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [3:0]            cfg_data,
    input  logic                  in_valid,
    input  logic                  acc_clr,
    input  logic [2*PART_W-1:0]   op_a,
    input  logic [2*PART_W-1:0]   op_b,
    input  logic [2*PART_W-1:0]   op_c,
    output logic                  out_valid,
    output logic [2*CACC_W-1:0]   acc_out,
    output logic                  ovf
);

    localparam int FACC_W = 2 * CACC_W;

    cfg_t                   cfg;
    logic [1:0][CACC_W-1:0] cprod, cthird;
    logic [FACC_W-1:0]      fprod, fthird;

    rmac_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_data),
        .cfg   (cfg)
    );

    rmac_mult #(
        .PART_W (PART_W),
        .CACC_W (CACC_W)
    ) u_mult (
        .cfg    (cfg),
        .a      (op_a),
        .b      (op_b),
        .c      (op_c),
        .cprod  (cprod),
        .cthird (cthird),
        .fprod  (fprod),
        .fthird (fthird)
    );

    rmac_acc #(
        .CACC_W (CACC_W)
    ) u_acc (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .cfg_we    (cfg_we),
        .in_valid  (in_valid),
        .acc_clr   (acc_clr),
        .cprod     (cprod),
        .cthird    (cthird),
        .fprod     (fprod),
        .fthird    (fthird),
        .acc       (acc_out),
        .ovf       (ovf),
        .out_valid (out_valid)
    );

endmodule

// File: rtl/rmac_unit_chk.sv
module rmac_unit_chk #(
    parameter int CACC_W = 20
) (
    input logic                clk,
    input logic                rst,
    input logic                cfg_we,
    input logic                in_valid,
    input logic                acc_clr,
    input logic                out_valid,
    input logic [2*CACC_W-1:0] acc_out,
    input logic                ovf
);

    // R6
    out_valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cfg_we) |=> out_valid);

    // R6
    no_valid_no_out_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid || cfg_we) |=> !out_valid);

    // R2
    cfg_write_clears_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (acc_out == '0 && !ovf));

    // R7
    idle_clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_clr && !in_valid && !cfg_we) |=> (acc_out == '0 && !ovf));

    // R7
    load_clear_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_clr && in_valid && !cfg_we) |=> !ovf);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !acc_clr && !cfg_we) |=> ($stable(acc_out) && $stable(ovf)));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && !acc_clr && !cfg_we) |=> ovf);

endmodule

bind rmac_unit rmac_unit_chk #(.CACC_W(CACC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .in_valid  (in_valid),
    .acc_clr   (acc_clr),
    .out_valid (out_valid),
    .acc_out   (acc_out),
    .ovf       (ovf)
);

// File: tb/tb_rmac_unit.sv
`timescale 1ns/1ps
module tb_rmac_unit;

    localparam int PW = 8;
    localparam int CW = 18;
    localparam int FW = 2 * CW;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic [3:0]    cfg_data;
    logic          in_valid;
    logic          acc_clr;
    logic [15:0]   op_a, op_b, op_c;
    logic          out_valid;
    logic [FW-1:0] acc_out;
    logic          ovf;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rmac_unit #(.PART_W(PW), .CACC_W(CW)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_data(cfg_data),
        .in_valid(in_valid), .acc_clr(acc_clr),
        .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .out_valid(out_valid), .acc_out(acc_out), .ovf(ovf)
    );

    typedef struct packed {
        logic [7:0]  ar, ai, br, bi;
        logic        clr;
        logic [17:0] er, ei;
    } vec_t;

    // Complex accumulate sequence; expected lanes are running totals.
    localparam vec_t VECS [5] = '{
        '{8'd1,     8'd2,     8'd3,     8'd4,     1'b1, -18'sd5,  18'sd10},
        '{-8'sd2,   8'd1,     8'd5,     -8'sd3,   1'b0, -18'sd12, 18'sd21},
        '{8'd0,     -8'sd1,   8'd7,     8'd7,     1'b0, -18'sd5,  18'sd14},
        '{8'd10,    8'd0,     -8'sd1,   8'd0,     1'b1, -18'sd10, 18'sd0},
        '{8'h80,    8'h80,    8'h80,    8'h80,    1'b0, -18'sd10, 18'sd32768}
    };

    function automatic logic [FW-1:0] cx(input int re, input int im);
        logic [31:0] r, i;
        r = re;
        i = im;
        return {r[CW-1:0], i[CW-1:0]};
    endfunction

    function automatic logic [15:0] pk(input int re, input int im);
        logic [31:0] r, i;
        r = re;
        i = im;
        return {r[7:0], i[7:0]};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
                         input logic v, input logic clr);
        op_a = a; op_b = b; op_c = c;
        in_valid = v; acc_clr = clr; cfg_we = 1'b0;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; acc_clr = 1'b0;
    endtask

    task automatic write_cfg(input logic [3:0] d, input logic v);
        cfg_data = d; cfg_we = 1'b1; in_valid = v; acc_clr = 1'b0;
        op_a = 16'h0505; op_b = 16'h0505; op_c = 16'h0;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0; in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [FW-1:0] model;
        rst = 1'b1; cfg_we = 1'b0; cfg_data = 4'h0; in_valid = 1'b0; acc_clr = 1'b0;
        op_a = '0; op_b = '0; op_c = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 acc", acc_out, 0);
        chk("R1 ovf", ovf, 0);
        chk("R1 out_valid", out_valid, 0);

        // R1/R4 default mode is fixed unsigned accumulate
        issue(16'd3, 16'd5, 16'd0, 1'b1, 1'b0);
        chk("R1 default mode acc", acc_out, 15);
        chk("R6 out_valid", out_valid, 1);

        // R4 unsigned full-scale square is zero-extended
        issue(16'hFFFF, 16'hFFFF, 16'd0, 1'b1, 1'b1);
        chk("R4 unsigned square", acc_out, 36'h0FFFE0001);

        // R10 idle cycle holds
        issue(16'h1234, 16'h1234, 16'd0, 1'b0, 1'b0);
        chk("R10 hold acc", acc_out, 36'h0FFFE0001);
        chk("R10 out_valid low", out_valid, 0);

        // R2 mode write clears, drops simultaneous valid
        write_cfg(4'b0010, 1'b1);
        chk("R2 clear acc", acc_out, 0);
        chk("R2 dropped valid", out_valid, 0);

        // R5 signed fixed
        issue(16'hFFFF, 16'h0003, 16'd0, 1'b1, 1'b0);
        chk("R5 signed -3", acc_out, 36'hFFFFFFFFD);
        issue(16'h8000, 16'h0002, 16'd0, 1'b1, 1'b0);
        chk("R5 signed accumulate", acc_out, 36'hFFFFEFFFD);

        // R3 complex table walk
        write_cfg(4'b0001, 1'b0);
        for (int i = 0; i < 5; i++) begin
            issue({VECS[i].ar, VECS[i].ai}, {VECS[i].br, VECS[i].bi}, 16'd0, 1'b1, VECS[i].clr);
            chk("R3 complex vector", acc_out, {VECS[i].er, VECS[i].ei});
            chk("R6 valid per pair", out_valid, 1);
        end

        // R8 third operand forms, complex
        write_cfg(4'b0101, 1'b0);
        issue(pk(1, 2), pk(3, 4), pk(5, -6), 1'b1, 1'b0);
        chk("R8 complex c+p", acc_out, cx(0, 4));
        issue(pk(1, 2), pk(3, 4), pk(5, -6), 1'b1, 1'b0);
        chk("R8 no accumulation", acc_out, cx(0, 4));
        write_cfg(4'b1001, 1'b0);
        issue(pk(1, 2), pk(3, 4), pk(5, -6), 1'b1, 1'b0);
        chk("R8 complex c-p", acc_out, cx(10, -16));

        // R8 third operand forms, fixed
        write_cfg(4'b0110, 1'b0);
        issue(16'd7, 16'hFFFE, 16'd100, 1'b1, 1'b0);
        chk("R8 fixed signed c+p", acc_out, 86);
        write_cfg(4'b1000, 1'b0);
        issue(16'd2, 16'd3, 16'd16, 1'b1, 1'b0);
        chk("R8 fixed unsigned c-p", acc_out, 10);

        // R2 operation code 11 accumulates
        write_cfg(4'b1101, 1'b0);
        issue(pk(1, 2), pk(3, 4), 16'd0, 1'b1, 1'b0);
        issue(pk(1, 2), pk(3, 4), 16'd0, 1'b1, 1'b0);
        chk("R2 op 11 accumulates", acc_out, cx(-10, 20));

        // R9 complex lane wrap and sticky flag
        write_cfg(4'b0001, 1'b0);
        for (int i = 0; i < 3; i++) issue(16'h8080, 16'h8080, 16'd0, 1'b1, 1'b0);
        chk("R9 complex before wrap", acc_out, cx(0, 98304));
        chk("R9 no ovf yet", ovf, 0);
        issue(16'h8080, 16'h8080, 16'd0, 1'b1, 1'b0);
        chk("R9 complex wrapped", acc_out, {18'd0, 18'h20000});
        chk("R9 complex ovf", ovf, 1);
        issue(pk(1, 2), pk(3, 4), 16'd0, 1'b1, 1'b0);
        chk("R9 wrapped accumulate", acc_out, {18'h3FFFB, 18'h2000A});
        chk("R9 ovf sticky", ovf, 1);
        issue(pk(1, 2), pk(3, 4), 16'd0, 1'b1, 1'b1);
        chk("R7 load product", acc_out, cx(-5, 10));
        chk("R7 ovf cleared", ovf, 0);

        // R9 fixed unsigned carry out
        write_cfg(4'b0000, 1'b0);
        model = '0;
        for (int i = 0; i < 16; i++) begin
            issue(16'hFFFF, 16'hFFFF, 16'd0, 1'b1, 1'b0);
            model = model + 36'h0FFFE0001;
        end
        chk("R9 unsigned before carry", acc_out, model);
        chk("R9 unsigned no ovf", ovf, 0);
        issue(16'hFFFF, 16'hFFFF, 16'd0, 1'b1, 1'b0);
        model = model + 36'h0FFFE0001;
        chk("R9 unsigned wrapped", acc_out, model);
        chk("R9 unsigned ovf", ovf, 1);

        // R9 fixed signed overflow
        write_cfg(4'b0010, 1'b0);
        chk("R2 ovf cleared by write", ovf, 0);
        for (int i = 0; i < 31; i++) issue(16'h8000, 16'h8000, 16'd0, 1'b1, 1'b0);
        chk("R9 signed before ovf", acc_out, 36'h7C0000000);
        chk("R9 signed no ovf", ovf, 0);
        issue(16'h8000, 16'h8000, 16'd0, 1'b1, 1'b0);
        chk("R9 signed wrapped", acc_out, 36'h800000000);
        chk("R9 signed ovf", ovf, 1);

        // R7 clear without valid
        issue(16'd9, 16'd9, 16'd0, 1'b0, 1'b1);
        chk("R7 idle clear acc", acc_out, 0);
        chk("R7 idle clear ovf", ovf, 0);
        chk("R7 idle clear out_valid", out_valid, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule